// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an auto-zeroing, auto-polarity dual-slope converter. It walks a fixed six-phase cycle and drives the analog switch selects from it. The phases are: short the integrator while charging the offset capacitor, measure the comparator offset, a second short/charge phase, ramp up on the unknown input, replay the offset, and ramp down on the reference. Its only analog input is a single comparator bit, which is passed through a two-flop synchronizer.

Auto-zero is done in the count domain. The clocks the integrator needs to reach the comparator threshold in the offset phase are stored. The same number of clocks is then spent on the reference before the measuring window opens. Within that window, the clocks before the comparator flips give the reading: the count is halved and clamped to full scale. The sign found at the end of the up-ramp is published with the reading and selects the reference polarity for the following cycle.

Top module: `dslope_seq`

## Requirements
- R1: While reset is low and on the first clock after it, short and charge selects are 1, input and reference selects are 0, and ref_neg_o, neg_o, ovr_o, done_o and result_o are all 0.
- R2: Phases 1, 3 and 4 each last exactly SEG_LEN clocks. Phases 1 and 3 assert short and charge. Phase 4 asserts only the input select.
- R3: In phase 2 all four selects are 0. The comparator is sampled through two flops, and a synchronized 0 means threshold reached. The clocks spent in phase 2 before that sample are stored as the offset, so the phase lasts offset+1 clocks. A comparator already low on entry gives offset 0.
- R4: If no threshold is seen, phase 2 ends after AZ_MAX clocks and the offset saturates at AZ_MAX-1.
- R5: The reference select is 1 for the offset clocks of phase 5 plus the phase 6 window. An offset of 0 skips phase 5.
- R6: Phase 6 ends on the first clock where the synchronized comparator differs from the latched sign. result_o is then the phase-6 clock count divided by two, clamped at FULL = SEG_LEN/2-1 (1999 by default).
- R7: If no flip occurs within SEG_LEN phase-6 clocks, ovr_o is 1 and result_o is FULL. Otherwise ovr_o is 0.
- R8: The comparator value at the last phase-4 clock is the sign, with 1 meaning positive. neg_o and ref_neg_o both take its inverse when the cycle ends. ref_neg_o changes at no other time, so it holds the previous cycle's polarity during phase 4.
- R9: done_o is high for exactly one clock: the first clock of the next phase 1. It is raised together with the updates to result_o, ovr_o and neg_o.
- R10: At no time is more than one of short, input select and reference select active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator, 1 = integrator above threshold |
| sw_short_o | output | 1 | Short the integrator capacitor |
| sw_azc_o | output | 1 | Charge the offset capacitor |
| sw_in_o | output | 1 | Connect the unknown input |
| sw_ref_o | output | 1 | Connect the reference |
| ref_neg_o | output | 1 | Reference polarity, 1 = negative input last cycle |
| result_o | output | RES_W | Magnitude of the reading |
| neg_o | output | 1 | Sign of the reading, 1 = negative |
| ovr_o | output | 1 | Reading over full scale |
| done_o | output | 1 | One-clock pulse when a reading is published |

## Verification
The conversion is run with both input signs and with several offset delays: an offset already present on entry, short delays, and one that never trips and so saturates. Each is combined with down-ramp flip points that give small, mid-range and exactly full-scale readings, plus one window with no flip at all. Measuring the phase-2 length and the total reference time separates a wrong offset capture from a wrong replay. Alternating signs show whether the polarity output lags by one cycle as required. A reset in the middle of the up-ramp after a negative over-range reading shows that every published value is cleared.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [2:0] {
    SEG_AZ1 = 3'd0,
    SEG_OFS = 3'd1,
    SEG_AZ2 = 3'd2,
    SEG_UP  = 3'd3,
    SEG_DN  = 3'd4,
    SEG_WIN = 3'd5
  } seg_e;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int SEG_LEN = 4000,
  parameter int AZ_MAX  = 800,
  parameter int CNT_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_s_i,
  output seg_e             seg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sign_o,
  output logic             end_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(SEG_LEN - 1);
  localparam logic [CNT_W-1:0] AZ_LAST = CNT_W'(AZ_MAX - 1);

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ofs_q, ofs_d;
  logic             sign_q, sign_d;
  logic             trip_az, trip_win;

  assign trip_az  = ~cmp_s_i;
  assign trip_win = cmp_s_i ^ sign_q;

  always_comb begin
    seg_d  = seg_q;
    cnt_d  = cnt_q + 1'b1;
    ofs_d  = ofs_q;
    sign_d = sign_q;
    end_o  = 1'b0;
    ovr_o  = 1'b0;
    unique case (seg_q)
      SEG_AZ1: if (cnt_q == LAST) begin
        seg_d = SEG_OFS;
        cnt_d = '0;
      end
      SEG_OFS: if (trip_az || cnt_q == AZ_LAST) begin
        ofs_d = cnt_q;
        seg_d = SEG_AZ2;
        cnt_d = '0;
      end
      SEG_AZ2: if (cnt_q == LAST) begin
        seg_d = SEG_UP;
        cnt_d = '0;
      end
      SEG_UP: if (cnt_q == LAST) begin
        sign_d = cmp_s_i;
        seg_d  = (ofs_q == '0) ? SEG_WIN : SEG_DN;
        cnt_d  = '0;
      end
      SEG_DN: if (cnt_q == ofs_q - 1'b1) begin
        seg_d = SEG_WIN;
        cnt_d = '0;
      end
      SEG_WIN: if (trip_win || cnt_q == LAST) begin
        end_o = 1'b1;
        ovr_o = ~trip_win;
        seg_d = SEG_AZ1;
        cnt_d = '0;
      end
      default: begin
        seg_d = SEG_AZ1;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_AZ1;
      cnt_q  <= '0;
      ofs_q  <= '0;
      sign_q <= 1'b1;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ofs_q  <= ofs_d;
      sign_q <= sign_d;
    end
  end

  assign seg_o  = seg_q;
  assign cnt_o  = cnt_q;
  assign sign_o = sign_q;
endmodule

// File: rtl/dslope_read.sv
module dslope_read #(
  parameter int CNT_W = 12,
  parameter int RES_W = 11,
  parameter int FULL  = 1999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  logic             ovr_i,
  input  logic             sign_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [RES_W-1:0] result_o,
  output logic             neg_o,
  output logic             ovr_o,
  output logic             done_o
);
  localparam logic [CNT_W-2:0] FULL_H = (CNT_W-1)'(FULL);

  logic [CNT_W-2:0] half;
  logic [RES_W-1:0] res_q, res_d;
  logic             neg_q, ovr_q, done_q;

  assign half = cnt_i[CNT_W-1:1];

  always_comb begin
    if (ovr_i || half > FULL_H) res_d = RES_W'(FULL);
    else                        res_d = RES_W'(half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      neg_q  <= 1'b0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_i;
      if (end_i) begin
        res_q <= res_d;
        neg_q <= ~sign_i;
        ovr_q <= ovr_i;
      end
    end
  end

  assign result_o = res_q;
  assign neg_o    = neg_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter  int SEG_LEN = 4000,
  parameter  int AZ_MAX  = 800,
  parameter  int SYNC_N  = 2,
  localparam int CNT_W   = $clog2(SEG_LEN),
  localparam int FULL    = SEG_LEN / 2 - 1,
  localparam int RES_W   = $clog2(SEG_LEN / 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  output logic             sw_short_o,
  output logic             sw_azc_o,
  output logic             sw_in_o,
  output logic             sw_ref_o,
  output logic             ref_neg_o,
  output logic [RES_W-1:0] result_o,
  output logic             neg_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic             cmp_s, sign, win_end, win_ovr;
  seg_e             seg;
  logic [CNT_W-1:0] cnt;

  dslope_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cmp_i), .q_o(cmp_s)
  );

  dslope_ctrl #(.SEG_LEN(SEG_LEN), .AZ_MAX(AZ_MAX), .CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_s_i(cmp_s),
    .seg_o  (seg),
    .cnt_o  (cnt),
    .sign_o (sign),
    .end_o  (win_end),
    .ovr_o  (win_ovr)
  );

  dslope_read #(.CNT_W(CNT_W), .RES_W(RES_W), .FULL(FULL)) u_read (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .end_i   (win_end),
    .ovr_i   (win_ovr),
    .sign_i  (sign),
    .cnt_i   (cnt),
    .result_o(result_o),
    .neg_o   (neg_o),
    .ovr_o   (ovr_o),
    .done_o  (done_o)
  );

  always_comb begin
    sw_short_o = (seg == SEG_AZ1) || (seg == SEG_AZ2);
    sw_azc_o   = sw_short_o;
    sw_in_o    = (seg == SEG_UP);
    sw_ref_o   = (seg == SEG_DN) || (seg == SEG_WIN);
  end

  assign ref_neg_o = neg_o;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int RES_W = 11,
  parameter int FULL  = 1999
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_short_o,
  input logic             sw_in_o,
  input logic             sw_ref_o,
  input logic             ref_neg_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o
);
  // R10
  excl_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_short_o, sw_in_o, sw_ref_o}));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_in_az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sw_short_o);

  // R2
  up_after_az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_in_o) |-> $past(sw_short_o));

  // R8
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_neg_o) |-> done_o);

  // R6
  res_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(result_o) <= FULL));
endmodule

bind dslope_seq dslope_seq_chk #(.RES_W(RES_W), .FULL(FULL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_short_o(sw_short_o),
  .sw_in_o   (sw_in_o),
  .sw_ref_o  (sw_ref_o),
  .ref_neg_o (ref_neg_o),
  .result_o  (result_o),
  .done_o    (done_o)
);

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
  localparam int L    = 40;
  localparam int AZ   = 8;
  localparam int FS   = L / 2 - 1;
  localparam int RW   = $clog2(L / 2);
  localparam int NV   = 6;
  // columns: positive, offset trip delay (0 = low on entry), window flip delay (0 = none)
  localparam int V_POS[NV] = '{1, 0, 1, 1, 1, 0};
  localparam int V_K  [NV] = '{3, 2, 0, 1, 20, 5};
  localparam int V_M  [NV] = '{10, 25, 20, 1, 37, 0};
  // expected: offset, reading, over-range
  localparam int V_OFF[NV] = '{4, 3, 0, 2, 7, 6};
  localparam int V_RES[NV] = '{5, 13, 10, 1, 19, 19};
  localparam int V_OVR[NV] = '{0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b1;
  logic sw_short, sw_azc, sw_in, sw_ref, ref_neg, neg, ovr, done;
  logic [RW-1:0] result;
  int total = 0;
  int bad = 0;
  int prev_neg = 0;

  always #10 clk = ~clk;

  dslope_seq #(.SEG_LEN(L), .AZ_MAX(AZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
    .sw_short_o(sw_short), .sw_azc_o(sw_azc), .sw_in_o(sw_in), .sw_ref_o(sw_ref),
    .ref_neg_o(ref_neg), .result_o(result), .neg_o(neg), .ovr_o(ovr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(sw_short && sw_azc && !sw_in && !sw_ref, {req, " selects"},
        {sw_short, sw_azc, sw_in, sw_ref}, 4'b1100);
    chk(!ref_neg && !neg && !ovr && !done && result == 0, {req, " outputs"},
        {ref_neg, neg, ovr, done, result}, 0);
  endtask

  task automatic run_conv(input int pos, input int k, input int m,
                          input int eoff, input int eres, input int eovr);
    int n;
    cmp = (k == 0) ? 1'b0 : 1'b1;
    while (sw_short) @(negedge clk);
    n = 0;
    while (!sw_short && !sw_azc && !sw_in && !sw_ref) begin
      n++;
      if (n == k) cmp = 1'b0;
      @(negedge clk);
    end
    chk(n == eoff + 1, "R3/R4 offset phase length", n, eoff + 1);
    cmp = pos[0];
    n = 0;
    while (sw_short) begin n++; @(negedge clk); end
    chk(n == L, "R2 phase 3 length", n, L);
    chk(ref_neg == prev_neg[0], "R8 polarity during up-ramp", ref_neg, prev_neg);
    n = 0;
    while (sw_in) begin n++; @(negedge clk); end
    chk(n == L, "R2 phase 4 length", n, L);
    n = 0;
    while (sw_ref) begin
      n++;
      if (m != 0 && n == eoff + m) cmp = ~pos[0];
      @(negedge clk);
    end
    chk(n == eoff + (eovr != 0 ? L : m + 2), "R5 reference time", n,
        eoff + (eovr != 0 ? L : m + 2));
    chk(done == 1'b1, "R9 done raised", done, 1);
    chk(result == RW'(eres), "R6 reading", result, eres);
    chk(ovr == eovr[0], "R7 over-range", ovr, eovr);
    chk(neg == ~pos[0] && ref_neg == ~pos[0], "R8 sign", neg, !pos);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one clock", done, 0);
    prev_neg = pos == 0 ? 1 : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");
    for (int i = 0; i < NV; i++)
      run_conv(V_POS[i], V_K[i], V_M[i], V_OFF[i], V_RES[i], V_OVR[i]);
    // mid-conversion reset after a negative over-range reading
    cmp = 1'b1;
    while (!sw_in) @(negedge clk);
    chk(ref_neg == 1'b1, "R8 polarity kept before reset", ref_neg, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 reset during up-ramp");
    rst_n = 1'b1;
    n = 0;
    while (sw_short) begin n++; @(negedge clk); end
    chk(n == L, "R2 phase 1 length after reset", n, L);
    chk(!sw_short && !sw_in && !sw_ref, "R3 offset phase selects", sw_ref, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule